// File: doc/BRIEF.md
# Precise exception tracker

This block follows every instruction through a five-stage pipeline (fetch, decode, execute, memory, write-back). It carries an exception status vector alongside each instruction. Each stage can set its own cause bits in that vector while the instruction is there, but no stage acts on a fault when it sees it. The fault is only recorded. The decision is made at write-back. If the vector of the retiring instruction is empty, the instruction retires normally and may write the register file. If the vector holds any bit, the instruction's state update is cancelled. In the same cycle, every younger instruction is discarded and fetch is sent to a fixed handler address.

Faults are resolved in program order because they are resolved only at retirement. A memory-stage fault of an older load is therefore reported ahead of an earlier-detected fetch fault of a younger instruction. The pipeline also suppresses the memory write of any instruction that already carries a fault bit or raises one in the memory stage. No partial store becomes visible.

The faulting PC and a cause code are latched into holding registers, and a pending flag is raised. The registers keep their contents until the handler acknowledges them.

Top module: `precise_exc_tracker`

## Requirements
- R1: While reset is high, and on the first cycle after it, no instruction is valid. `commit_o`, `redirect_o`, `flush_o`, `mem_wr_en_o`, `rf_wr_en_o` and `exc_pending_o` are all 0.
- R2: A fault-free instruction presented with `fetch_valid_i` in cycle n retires in cycle n+5. In that cycle `commit_o` is 1, `commit_pc_o` equals its fetch PC, and `rf_wr_en_o` equals the `wb_wr_req_i` value applied in that cycle.
- R3: The status vector has these bit positions: bits 0..2 for fetch (page fault, misaligned, protection); bit 3 for illegal opcode; bit 4 for arithmetic; bits 5..7 for memory (page fault, misaligned, protection). The cause code is the index of the lowest set bit plus one, so the fault from the earliest stage takes priority. Code 0 means no fault.
- R4: In the cycle a faulting instruction reaches write-back, `flush_o` and `redirect_o` are 1 and `redirect_pc_o` equals `HANDLER_PC`. In that same cycle `commit_o` and `rf_wr_en_o` are 0.
- R5: The four younger instructions in flight and the one presented in the same cycle as the faulting retirement never retire, never write memory and never raise an exception.
- R6: An older instruction's fault found in the memory stage is reported before a younger instruction's fault found earlier in fetch.
- R7: `mem_wr_en_o` follows `mem_wr_req_i` for a valid memory-stage instruction only when its vector is empty and `mem_flt_i` is 0.
- R8: Fault inputs applied to an empty pipeline slot have no effect.
- R9: On a faulting retirement with nothing pending, `exc_pc_o` and `exc_cause_o` are captured and `exc_pending_o` rises in the next cycle. While pending and not acknowledged, they hold their values and later faults do not overwrite them. A lone `ack_i` clears pending.
- R10: If `ack_i` and a faulting retirement fall in the same cycle, the new fault is captured and pending stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | An instruction enters fetch this cycle |
| fetch_pc_i | input | PC_W | PC of the entering instruction |
| fetch_flt_i | input | 3 | Fetch faults: {protection, misaligned, page} |
| dec_illegal_i | input | 1 | Decode-stage instruction has an illegal opcode |
| exe_arith_i | input | 1 | Execute-stage instruction raised an arithmetic fault |
| mem_flt_i | input | 3 | Memory-stage faults: {protection, misaligned, page} |
| mem_wr_req_i | input | 1 | Memory-stage instruction requests a store |
| wb_wr_req_i | input | 1 | Write-back instruction requests a register write |
| ack_i | input | 1 | Handler acknowledges the held exception |
| mem_wr_en_o | output | 1 | Store permitted |
| rf_wr_en_o | output | 1 | Register write permitted |
| commit_o | output | 1 | Clean retirement this cycle |
| commit_pc_o | output | PC_W | PC of the retiring instruction |
| flush_o | output | 1 | Discard all younger instructions |
| redirect_o | output | 1 | Redirect fetch to handler |
| redirect_pc_o | output | PC_W | Handler address |
| exc_pending_o | output | 1 | Held exception awaits acknowledge |
| exc_pc_o | output | PC_W | Held faulting PC |
| exc_cause_o | output | 4 | Held cause code |

## Verification
The case that needs care is the cycle in which a faulting instruction retires while the instruction one behind it sits in the memory stage with a store request. The faulting retirement must win, and that store must not reach the memory port. The bench provokes this by issuing a fetch-faulting instruction followed directly by a storing one. It also does this with a killed instruction that itself carries memory faults. It judges the result by comparing `mem_wr_en_o` in that cycle against its own expectation, which marks every instruction inside the flush shadow as never storing. A second collision is `ack_i` arriving in the same cycle as a new faulting retirement; the bench checks that the new fault is the one held.

// File: rtl/xtrk_pkg.sv
package xtrk_pkg;
  localparam int NSTG    = 5;
  localparam int IF_W    = 3;
  localparam int MEM_W   = 3;
  localparam int VEC_W   = IF_W + 1 + 1 + MEM_W;
  localparam int CAUSE_W = $clog2(VEC_W + 1);
  localparam int B_IF    = 0;
  localparam int B_ILL   = B_IF + IF_W;
  localparam int B_ARI   = B_ILL + 1;
  localparam int B_MEM   = B_ARI + 1;
  localparam int ST_MEM  = NSTG - 2;
  localparam int ST_WB   = NSTG - 1;
endpackage

// File: rtl/xtrk_stage.sv
module xtrk_stage
  import xtrk_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kill,
  input  logic             in_valid,
  input  logic [PC_W-1:0]  in_pc,
  input  logic [VEC_W-1:0] in_vec,
  output logic             valid_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [VEC_W-1:0] vec_o
);
  always_ff @(posedge clk) begin
    if (rst || kill) begin
      valid_o <= 1'b0;
      pc_o    <= '0;
      vec_o   <= '0;
    end else begin
      valid_o <= in_valid;
      pc_o    <= in_pc;
      vec_o   <= in_valid ? in_vec : '0;
    end
  end
endmodule

// File: rtl/xtrk_cause_enc.sv
module xtrk_cause_enc
  import xtrk_pkg::*;
(
  input  logic [VEC_W-1:0]   vec,
  output logic [CAUSE_W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (vec[i]) code = CAUSE_W'(i + 1);
    end
  end
endmodule

// File: rtl/xtrk_hold.sv
module xtrk_hold
  import xtrk_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic [PC_W-1:0]    take_pc,
  input  logic [CAUSE_W-1:0] take_cause,
  input  logic               ack,
  output logic               pend_o,
  output logic [PC_W-1:0]    pc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o  <= 1'b0;
      pc_o    <= '0;
      cause_o <= '0;
    end else if (take && (!pend_o || ack)) begin
      pend_o  <= 1'b1;
      pc_o    <= take_pc;
      cause_o <= take_cause;
    end else if (ack) begin
      pend_o  <= 1'b0;
    end
  end

  // R9: an unacknowledged held exception is never overwritten
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !ack) |=> (pend_o && $stable(pc_o) && $stable(cause_o)));

  // R10: acknowledge coinciding with a new fault keeps pending set
  a_r10_ack_and_take: assert property (@(posedge clk) disable iff (rst)
    (take && ack) |=> pend_o);
endmodule

// File: rtl/precise_exc_tracker.sv
module precise_exc_tracker
  import xtrk_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = PC_W'(32'h0000_0180)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_valid_i,
  input  logic [PC_W-1:0]    fetch_pc_i,
  input  logic [IF_W-1:0]    fetch_flt_i,
  input  logic               dec_illegal_i,
  input  logic               exe_arith_i,
  input  logic [MEM_W-1:0]   mem_flt_i,
  input  logic               mem_wr_req_i,
  input  logic               wb_wr_req_i,
  input  logic               ack_i,
  output logic               mem_wr_en_o,
  output logic               rf_wr_en_o,
  output logic               commit_o,
  output logic [PC_W-1:0]    commit_pc_o,
  output logic               flush_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic               exc_pending_o,
  output logic [PC_W-1:0]    exc_pc_o,
  output logic [CAUSE_W-1:0] exc_cause_o
);
  logic             stg_vld [NSTG];
  logic [PC_W-1:0]  stg_pc  [NSTG];
  logic [VEC_W-1:0] stg_vec [NSTG];
  logic             nxt_vld [NSTG];
  logic [PC_W-1:0]  nxt_pc  [NSTG];
  logic [VEC_W-1:0] nxt_vec [NSTG];
  logic [VEC_W-1:0] raise   [NSTG];

  logic               exc_take;
  logic [CAUSE_W-1:0] wb_cause;

  // Cause bits raised by the stage an instruction currently occupies
  always_comb begin
    for (int k = 0; k < NSTG; k++) raise[k] = '0;
    raise[1]      = VEC_W'(dec_illegal_i) << B_ILL;
    raise[2]      = VEC_W'(exe_arith_i) << B_ARI;
    raise[ST_MEM] = VEC_W'(mem_flt_i) << B_MEM;
  end

  always_comb begin
    nxt_vld[0] = fetch_valid_i;
    nxt_pc[0]  = fetch_pc_i;
    nxt_vec[0] = VEC_W'(fetch_flt_i) << B_IF;
    for (int k = 1; k < NSTG; k++) begin
      nxt_vld[k] = stg_vld[k-1];
      nxt_pc[k]  = stg_pc[k-1];
      nxt_vec[k] = stg_vec[k-1] | raise[k-1];
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    xtrk_stage #(.PC_W(PC_W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .kill     (exc_take),
      .in_valid (nxt_vld[g]),
      .in_pc    (nxt_pc[g]),
      .in_vec   (nxt_vec[g]),
      .valid_o  (stg_vld[g]),
      .pc_o     (stg_pc[g]),
      .vec_o    (stg_vec[g])
    );
  end

  xtrk_cause_enc u_enc (
    .vec  (stg_vec[ST_WB]),
    .code (wb_cause)
  );

  assign exc_take      = stg_vld[ST_WB] && (stg_vec[ST_WB] != '0);
  assign commit_o      = stg_vld[ST_WB] && (stg_vec[ST_WB] == '0);
  assign commit_pc_o   = stg_pc[ST_WB];
  assign rf_wr_en_o    = commit_o && wb_wr_req_i;
  assign flush_o       = exc_take;
  assign redirect_o    = exc_take;
  assign redirect_pc_o = HANDLER_PC;
  assign mem_wr_en_o   = mem_wr_req_i && stg_vld[ST_MEM] && (stg_vec[ST_MEM] == '0)
                         && (mem_flt_i == '0) && !exc_take;

  xtrk_hold #(.PC_W(PC_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .take       (exc_take),
    .take_pc    (stg_pc[ST_WB]),
    .take_cause (wb_cause),
    .ack        (ack_i),
    .pend_o     (exc_pending_o),
    .pc_o       (exc_pc_o),
    .cause_o    (exc_cause_o)
  );

  // R4: a redirecting retirement never writes the register file
  a_r4_no_rf_on_redirect: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> !rf_wr_en_o);

  // R5: after a flush, nothing reaches write-back in the next cycle
  a_r5_flush_empties_wb: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> (!commit_o && !redirect_o));

  // R5: after a flush, the memory stage holds no store
  a_r5_no_store_after_flush: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !mem_wr_en_o);

  // R9: pending rises only after a faulting retirement
  a_r9_pending_source: assert property (@(posedge clk) disable iff (rst)
    $rose(exc_pending_o) |-> $past(flush_o));

  // R3: a held exception always carries a non-zero cause
  a_r3_cause_nonzero: assert property (@(posedge clk) disable iff (rst)
    exc_pending_o |-> (exc_cause_o != '0));
endmodule

// File: tb/precise_exc_tracker_bench.sv
module precise_exc_tracker_bench;
  localparam int          CLK_P = 10;
  localparam logic [31:0] HVEC  = 32'h0000_0180;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid_i = 0;
  logic [31:0] fetch_pc_i = 0;
  logic [2:0]  fetch_flt_i = 0;
  logic        dec_illegal_i = 0, exe_arith_i = 0;
  logic [2:0]  mem_flt_i = 0;
  logic        mem_wr_req_i = 0, wb_wr_req_i = 0, ack_i = 0;
  logic        mem_wr_en_o, rf_wr_en_o, commit_o, flush_o, redirect_o, exc_pending_o;
  logic [31:0] commit_pc_o, redirect_pc_o, exc_pc_o;
  logic [3:0]  exc_cause_o;

  always #(CLK_P/2) clk = ~clk;

  precise_exc_tracker #(.PC_W(32), .HANDLER_PC(HVEC)) u_precise_exc_tracker (
    .clk(clk), .rst(rst), .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
    .fetch_flt_i(fetch_flt_i), .dec_illegal_i(dec_illegal_i), .exe_arith_i(exe_arith_i),
    .mem_flt_i(mem_flt_i), .mem_wr_req_i(mem_wr_req_i), .wb_wr_req_i(wb_wr_req_i),
    .ack_i(ack_i), .mem_wr_en_o(mem_wr_en_o), .rf_wr_en_o(rf_wr_en_o),
    .commit_o(commit_o), .commit_pc_o(commit_pc_o), .flush_o(flush_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .exc_pending_o(exc_pending_o), .exc_pc_o(exc_pc_o), .exc_cause_o(exc_cause_o));

  typedef struct {
    bit          exc;
    logic [31:0] pc;
    logic [3:0]  cause;
    bit          wr;
    int          due;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0, slot = 0, kill = 0, cur_slot = -1;
  bit mon_on = 0, cur_ack = 0, cur_mwe = 0, done = 0;
  logic       r_dec[8], r_ex[8], r_mwr[8], r_wwr[8], r_mwe[8];
  logic [2:0] r_mf[8];
  bit          pm = 0;
  logic [31:0] mpc = 0;
  logic [3:0]  mc = 0;
  logic [31:0] p = 32'h100;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R3: cause = index of lowest set vector bit + 1
  function automatic logic [3:0] cause_of(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 4'(i + 1);
    return 4'd0;
  endfunction

  // Driver: applies one slot and pushes the expected retirement
  task automatic step(bit v, logic [2:0] ff, bit dil, bit ear, logic [2:0] mf,
                      bit mwr, bit wwr, bit ack);
    int i;
    logic [7:0] vec;
    @(negedge clk);
    i = slot % 8;
    fetch_valid_i = v;  fetch_pc_i = v ? p : 32'h0;  fetch_flt_i = ff;
    dec_illegal_i = r_dec[i]; exe_arith_i = r_ex[i]; mem_flt_i = r_mf[i];
    mem_wr_req_i = r_mwr[i];  wb_wr_req_i = r_wwr[i]; ack_i = ack;
    cur_mwe = r_mwe[i]; cur_ack = ack; cur_slot = slot;
    r_dec[i] = 0; r_ex[i] = 0; r_mf[i] = 0; r_mwr[i] = 0; r_wwr[i] = 0; r_mwe[i] = 0;
    r_dec[(slot+2)%8] = dil; r_ex[(slot+3)%8] = ear; r_mf[(slot+4)%8] = mf;
    r_mwr[(slot+4)%8] = mwr; r_wwr[(slot+5)%8] = wwr;
    vec = {mf, ear, dil, ff};
    if (kill > 0) kill--;
    else if (v) begin
      if (vec != 0) begin
        q.push_back('{1'b1, p, cause_of(vec), 1'b0, slot + 5});
        kill = 5;
      end else begin
        q.push_back('{1'b0, p, 4'd0, wwr, slot + 5});
        r_mwe[(slot+4)%8] = mwr;
      end
    end
    if (v) p = p + 4;
    slot++;
  endtask

  task automatic idle(int n, bit ack = 0);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, ack);
  endtask

  // Monitor: pops expected items and compares in mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (mon_on) begin
        bit ex_now;
        item_t it;
        ex_now = 0;
        chk(mem_wr_en_o == cur_mwe, "R7", "mem_wr_en_o", mem_wr_en_o, cur_mwe);
        if (q.size() > 0 && q[0].due == cur_slot) begin
          it = q.pop_front();
          if (it.exc) begin
            chk(redirect_o && flush_o && !commit_o && !rf_wr_en_o, "R4",
                "redirect/flush/commit/rf", {redirect_o, flush_o, commit_o, rf_wr_en_o}, 4'b1100);
            chk(redirect_pc_o == HVEC, "R4", "redirect_pc_o", redirect_pc_o, HVEC);
            ex_now = 1;
          end else begin
            chk(commit_o && !redirect_o, "R2", "commit_o", commit_o, 1);
            chk(commit_pc_o == it.pc, "R2", "commit_pc_o", commit_pc_o, it.pc);
            chk(rf_wr_en_o == it.wr, "R2", "rf_wr_en_o", rf_wr_en_o, it.wr);
          end
        end else begin
          chk(!commit_o && !redirect_o && !rf_wr_en_o, "R5/R8", "unexpected retirement",
              {commit_o, redirect_o, rf_wr_en_o}, 0);
        end
        chk(exc_pending_o == pm, "R9", "exc_pending_o", exc_pending_o, pm);
        if (pm) begin
          chk(exc_pc_o == mpc, "R9", "exc_pc_o", exc_pc_o, mpc);
          chk(exc_cause_o == mc, "R3", "exc_cause_o", exc_cause_o, mc);
        end
        if (ex_now && (!pm || cur_ack)) begin
          pm = 1; mpc = it.pc; mc = it.cause;
        end else if (cur_ack) pm = 0;
      end
    end
  end

  task automatic peek(string req, logic [31:0] epc, logic [3:0] ec);
    #(CLK_P/4);
    chk(exc_pending_o == 1'b1, req, "pending", exc_pending_o, 1);
    chk(exc_pc_o == epc, req, "held pc", exc_pc_o, epc);
    chk(exc_cause_o == ec, req, "held cause", exc_cause_o, ec);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", slot);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] pc_b, pc_c, pc_e, pc_f;
    for (int k = 0; k < 8; k++) begin
      r_dec[k] = 0; r_ex[k] = 0; r_mf[k] = 0; r_mwr[k] = 0; r_wwr[k] = 0; r_mwe[k] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk(!commit_o && !redirect_o && !flush_o && !mem_wr_en_o && !rf_wr_en_o && !exc_pending_o,
        "R1", "outputs in reset", {commit_o, redirect_o, flush_o, mem_wr_en_o, exc_pending_o}, 0);
    rst = 0;
    mon_on = 1;
    // R2: clean stream with alternating store / register write
    for (int k = 0; k < 6; k++) step(1, 0, 0, 0, 0, k % 2, (k + 1) % 2, 0);
    // R4 R5: fetch page fault; next one stores with a memory fault, both killed
    pc_b = p;
    step(1, 3'b001, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 3'b010, 1, 1, 0);
    step(0, 3'b111, 1, 1, 3'b111, 1, 1, 0);
    idle(5);
    peek("R3", pc_b, 4'd1);
    idle(1, 1);
    // R8: faults on an empty slot are ignored
    step(0, 3'b111, 1, 1, 3'b111, 1, 1, 0);
    idle(6);
    // R6: older memory fault vs younger earlier fetch fault
    pc_c = p;
    step(1, 0, 0, 0, 3'b001, 0, 1, 0);
    step(1, 3'b100, 0, 0, 0, 0, 1, 0);
    idle(6);
    peek("R6", pc_c, 4'd6);
    // R9: arithmetic fault with store while pending; held values unchanged
    pc_e = p;
    step(1, 0, 0, 1, 0, 1, 1, 0);
    idle(6);
    peek("R9", pc_c, 4'd6);
    // R10 R3: multi-bit fault retires in the ack cycle
    pc_f = p;
    step(1, 0, 1, 0, 3'b100, 0, 1, 0);
    idle(4);
    idle(1, 1);
    idle(1);
    peek("R10", pc_f, 4'd4);
    idle(1, 1);
    idle(2);
    // R7: live memory protection fault blocks its own store
    step(1, 0, 0, 0, 3'b100, 1, 1, 0);
    idle(6);
    idle(1, 1);
    // R5: younger store sits in memory stage as older fault retires
    step(1, 3'b010, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 1, 1, 0);
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 1, 1, 0);
    idle(2);
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 1, 0, 0);
    idle(8);
    #(CLK_P/2);
    mon_on = 0;
    chk(q.size() == 0, "R2", "items never retired", q.size(), 0);
    if (pc_e == 0) $display("unused");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule